// File: doc/BRIEF.md
# SMBus Line Watcher with Idle Release and Low-Clock Timeout

This block passively observes the clock (SCL) and data (SDA) wires of an SMBus segment on behalf of a controller. It never drives the wires. It resynchronises both wire samples into the system clock domain. From them it detects START and STOP conditions and keeps a busy/free indication for the bus. The controller uses this indication to decide when it may begin a transfer of its own.

The block releases the bus in two ways. The usual way is an observed STOP. The second way covers a bus where the STOP was never seen: the bus is declared free once both wires have stayed high for a programmable number of ticks. A separate timer measures how long SCL stays low. When SCL has been held low for the low limit (nominally 25 ms), the block raises a timeout flag. A fixed number of ticks later, inside the 10 ms recovery allowance, it issues a one-cycle communication reset. That reset clears the timeout flag and the busy indication.

All time limits are counted in ticks. A tick is one system clock out of every `tick_div`+1, so a single parameter set covers a range of system clock rates.

Top module: `smb_linewatch`

## Requirements
- R1: After reset, bus_busy, start_pulse, stop_pulse, low_timeout and comm_reset are all 0.
- R2: A falling SDA while SCL is high produces a one-cycle start_pulse. The pulse appears SYNC_STAGES clocks after the wires change.
- R3: bus_busy is 1 on the clock after start_pulse.
- R4: An SDA change while SCL is low produces neither start_pulse nor stop_pulse, and leaves bus_busy unchanged.
- R5: A rising SDA while SCL is high produces a one-cycle stop_pulse, and bus_busy is 0 on the following clock.
- R6: While busy, if SCL and SDA both stay high for IDLE_LIMIT ticks, bus_busy returns to 0 with no STOP. It stays 1 before that count is reached.
- R7: When SCL stays low for LOW_LIMIT consecutive ticks, low_timeout is set. It then stays 1 until comm_reset.
- R8: Every rising edge of SCL restarts the low-time count. Low periods shorter than LOW_LIMIT ticks never set low_timeout, however many of them occur in sequence.
- R9: comm_reset pulses exactly RESET_TICKS ticks after low_timeout is set, and only while low_timeout is 1. On the next clock, low_timeout and bus_busy are both 0.
- R10: comm_reset is high for exactly one clock.
- R11: A tick occurs once every tick_div+1 clocks, and every tick-based limit scales with it. With tick_div = 1, each limit takes twice as many clocks as with tick_div = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL wire sample |
| sda_in | input | 1 | Raw SDA wire sample |
| tick_div | input | DIV_W | Tick period minus one, in system clocks |
| bus_busy | output | 1 | Bus is owned by a transfer |
| start_pulse | output | 1 | One-cycle START indication |
| stop_pulse | output | 1 | One-cycle STOP indication |
| low_timeout | output | 1 | SCL held low past LOW_LIMIT ticks |
| comm_reset | output | 1 | One-cycle communication reset request |

## Verification
The bench toggles SDA while SCL is low. A detector that ignored SCL would report false START or STOP conditions, and a busy flag tied to it would drop mid-transfer. It releases the bus through the idle path by raising SDA only while SCL is low, so no STOP ever occurs. A design missing that path would stay busy forever; one with an off-by-one threshold would release too early or too late. It strings together SCL low periods just below the limit with brief highs between them; a counter that never restarted would time out falsely. It also measures the timeout and reset latencies at two tick rates, which catches a prescaler that is ignored or applied to only one of the timers.

// File: rtl/smb_linewatch_pkg.sv
package smb_linewatch_pkg;

   typedef struct packed {
      logic scl;
      logic sda;
   } line_t;

   localparam line_t LINES_IDLE = '{scl: 1'b1, sda: 1'b1};

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
   import smb_linewatch_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  line_t raw,
   output line_t cur,
   output line_t prev
);

   if (STAGES < 2) begin : g_bad_stages
      $error("smb_line_sync: STAGES must be at least 2");
   end

   // STAGES synchroniser flops plus one history flop for edge detection
   line_t [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){LINES_IDLE}};
      else        chain <= {chain[STAGES-1:0], raw};
   end

   assign cur  = chain[STAGES-1];
   assign prev = chain[STAGES];

endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect
   import smb_linewatch_pkg::*;
(
   input  line_t cur,
   input  line_t prev,
   output logic  start_cond,
   output logic  stop_cond
);

   logic scl_steady_high;

   assign scl_steady_high = cur.scl & prev.scl;
   assign start_cond = scl_steady_high &  prev.sda & ~cur.sda;
   assign stop_cond  = scl_steady_high & ~prev.sda &  cur.sda;

endmodule

// File: rtl/smb_tick_gen.sv
module smb_tick_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   if (DIV_W < 1) begin : g_bad_div
      $error("smb_tick_gen: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] phase;

   assign tick = (phase >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    phase <= '0;
      else if (tick) phase <= '0;
      else           phase <= phase + 1'b1;
   end

endmodule

// File: rtl/smb_low_timer.sv
module smb_low_timer #(
   parameter int LOW_LIMIT   = 25000,
   parameter int RESET_TICKS = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic scl_cur,
   input  logic scl_prev,
   output logic timeout,
   output logic comm_reset
);

   localparam int LW = $clog2(LOW_LIMIT + 1);
   localparam int RW = $clog2(RESET_TICKS + 1);
   localparam logic [LW-1:0] LOW_LAST = LW'(LOW_LIMIT - 1);
   localparam logic [RW-1:0] RST_LAST = RW'(RESET_TICKS - 1);

   if (LOW_LIMIT < 2) begin : g_bad_low
      $error("smb_low_timer: LOW_LIMIT must be at least 2");
   end
   if (RESET_TICKS < 1) begin : g_bad_rst
      $error("smb_low_timer: RESET_TICKS must be at least 1");
   end

   logic [LW-1:0] low_cnt;
   logic [RW-1:0] dl_cnt;
   logic          scl_rise;
   logic          low_hit;

   assign scl_rise = scl_cur & ~scl_prev;
   assign low_hit  = tick & ~scl_cur & ~timeout & (low_cnt == LOW_LAST);

   // low-time counter: restarted by SCL rising and by the reset pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       low_cnt <= '0;
      else if (comm_reset || scl_rise)  low_cnt <= '0;
      else if (tick && !scl_cur && !timeout && low_cnt != LOW_LAST)
                                        low_cnt <= low_cnt + 1'b1;
   end

   // timeout flag and bounded reset deadline
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timeout    <= 1'b0;
         dl_cnt     <= '0;
         comm_reset <= 1'b0;
      end else if (comm_reset) begin
         timeout    <= 1'b0;
         dl_cnt     <= '0;
         comm_reset <= 1'b0;
      end else if (low_hit) begin
         timeout    <= 1'b1;
      end else if (timeout && tick) begin
         if (dl_cnt == RST_LAST) comm_reset <= 1'b1;
         else                    dl_cnt     <= dl_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
   parameter int IDLE_LIMIT = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic both_high,
   output logic expire
);

   localparam int IW = $clog2(IDLE_LIMIT + 1);
   localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_LIMIT - 1);

   if (IDLE_LIMIT < 2) begin : g_bad_idle
      $error("smb_idle_timer: IDLE_LIMIT must be at least 2");
   end

   logic [IW-1:0] idle_cnt;

   assign expire = both_high & tick & (idle_cnt == IDLE_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              idle_cnt <= '0;
      else if (!both_high)                     idle_cnt <= '0;
      else if (tick && idle_cnt != IDLE_LAST)  idle_cnt <= idle_cnt + 1'b1;
   end

endmodule

// File: rtl/smb_linewatch.sv
module smb_linewatch
   import smb_linewatch_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DIV_W       = 8,
   parameter int LOW_LIMIT   = 25000,
   parameter int RESET_TICKS = 5000,
   parameter int IDLE_LIMIT  = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   input  logic [DIV_W-1:0] tick_div,
   output logic             bus_busy,
   output logic             start_pulse,
   output logic             stop_pulse,
   output logic             low_timeout,
   output logic             comm_reset
);

   line_t raw_lines;
   line_t cur_lines;
   line_t prev_lines;
   logic  tick;
   logic  idle_expire;

   assign raw_lines = '{scl: scl_in, sda: sda_in};

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_lines),
      .cur  (cur_lines),
      .prev (prev_lines)
   );

   smb_cond_detect u_cond (
      .cur       (cur_lines),
      .prev      (prev_lines),
      .start_cond(start_pulse),
      .stop_cond (stop_pulse)
   );

   smb_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .div  (tick_div),
      .tick (tick)
   );

   smb_low_timer #(.LOW_LIMIT(LOW_LIMIT), .RESET_TICKS(RESET_TICKS)) u_low (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .scl_cur   (cur_lines.scl),
      .scl_prev  (prev_lines.scl),
      .timeout   (low_timeout),
      .comm_reset(comm_reset)
   );

   smb_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .both_high(cur_lines.scl & cur_lines.sda),
      .expire   (idle_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     bus_busy <= 1'b0;
      else if (comm_reset || stop_pulse || idle_expire) bus_busy <= 1'b0;
      else if (start_pulse)                           bus_busy <= 1'b1;
   end

endmodule

// File: rtl/smb_linewatch_chk.sv
module smb_linewatch_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_busy,
   input logic start_pulse,
   input logic stop_pulse,
   input logic low_timeout,
   input logic comm_reset
);

   p_start_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_pulse && !comm_reset) |=> bus_busy);

   p_cond_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_pulse && stop_pulse));

   p_stop_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |=> !bus_busy);

   p_reset_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      comm_reset |-> low_timeout);

   p_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      comm_reset |=> (!low_timeout && !bus_busy));

   p_reset_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      comm_reset |=> !comm_reset);

endmodule

bind smb_linewatch smb_linewatch_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_busy   (bus_busy),
   .start_pulse(start_pulse),
   .stop_pulse (stop_pulse),
   .low_timeout(low_timeout),
   .comm_reset (comm_reset)
);

// File: tb/smb_linewatch_bench.sv
`timescale 1ns/1ps
module smb_linewatch_bench;

   localparam int DIV_W = 4;
   localparam int LOWL  = 20;
   localparam int RSTT  = 6;
   localparam int IDLEL = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             scl = 1'b1;
   logic             sda = 1'b1;
   logic [DIV_W-1:0] div = '0;
   logic             busy, st, sp, tmo, crst;
   int               n_vec = 0;
   int               n_bad = 0;
   bit               done = 1'b0;

   always #10 clk = ~clk;

   smb_linewatch #(.SYNC_STAGES(2), .DIV_W(DIV_W), .LOW_LIMIT(LOWL),
                   .RESET_TICKS(RSTT), .IDLE_LIMIT(IDLEL)) u_smb_linewatch (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .tick_div(div),
      .bus_busy(busy), .start_pulse(st), .stop_pulse(sp),
      .low_timeout(tmo), .comm_reset(crst)
   );

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_rng(input string req, input int act, input int lo, input int hi);
      n_vec++;
      if (act < lo || act > hi) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input logic c, input logic d);
      scl = c; sda = d;
   endtask

   // count negedges until sig rises, limit 400
   task automatic wait_tmo(output int n);
      n = 0;
      while (!tmo && n < 400) begin cyc(1); n++; end
   endtask
   task automatic wait_crst(output int n);
      n = 0;
      while (!crst && n < 400) begin cyc(1); n++; end
   endtask

   task automatic t_reset;
      check("R1 busy", busy, 0);
      check("R1 timeout", tmo, 0);
      check("R1 pulses", {st, sp, crst}, 0);
   endtask

   task automatic t_start;
      drive(1, 0);
      cyc(1); check("R2 start early", st, 0);
      cyc(1); check("R2 start", st, 1);
      check("R2 start not stop", sp, 0);
      cyc(1); check("R2 start one cycle", st, 0);
      check("R3 busy", busy, 1);
   endtask

   task automatic t_data_change;
      int seen = 0;
      drive(0, 0); cyc(3);
      drive(0, 1);
      for (int i = 0; i < 4; i++) begin cyc(1); seen |= (st | sp); end
      drive(0, 0);
      for (int i = 0; i < 4; i++) begin cyc(1); seen |= (st | sp); end
      check("R4 no condition", seen, 0);
      check("R4 busy kept", busy, 1);
   endtask

   task automatic t_stop;
      drive(1, 0); cyc(4);
      drive(1, 1);
      cyc(2); check("R5 stop", sp, 1);
      cyc(1); check("R5 stop one cycle", sp, 0);
      check("R5 free", busy, 0);
   endtask

   task automatic t_idle;
      drive(1, 0); cyc(3); check("R3 busy before idle", busy, 1);
      drive(0, 0); cyc(3);
      drive(0, 1); cyc(3);
      drive(1, 1);
      cyc(IDLEL - 1); check("R6 still busy", busy, 1);
      cyc(4); check("R6 idle free", busy, 0);
      check("R6 no stop seen", sp, 0);
   endtask

   task automatic t_restart;
      int flag = 0;
      for (int k = 0; k < 4; k++) begin
         drive(0, 1);
         for (int i = 0; i < LOWL - 6; i++) begin cyc(1); flag |= tmo; end
         drive(1, 1); cyc(3); flag |= tmo;
      end
      check("R8 no timeout", flag, 0);
   endtask

   task automatic t_timeout(input int scale);
      int n;
      drive(1, 0); cyc(4);
      check("R3 busy before timeout", busy, 1);
      drive(0, 0);
      wait_tmo(n);
      check_rng(scale == 1 ? "R7 timeout latency" : "R11 timeout latency",
                n, scale*LOWL, scale*LOWL + 3*scale + 1);
      wait_crst(n);
      check_rng(scale == 1 ? "R9 reset latency" : "R11 reset latency",
                n, scale*RSTT - scale + 1, scale*RSTT + 1);
      check("R9 flag at reset", tmo, 1);
      cyc(1);
      check("R10 reset one cycle", crst, 0);
      check("R9 flag cleared", tmo, 0);
      check("R9 busy cleared", busy, 0);
      drive(0, 1); cyc(3);
      drive(1, 1); cyc(3);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_start();
      t_data_change();
      t_stop();
      t_idle();
      t_restart();
      t_timeout(1);
      div = 4'd1;
      t_timeout(2);
      div = 4'd0;
      cyc(4);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule